// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block holds a parameterised number of independent timer channels (two or four). All of them run from the fast bus clock. Each channel has a 56-bit interval register and a 56-bit down-counter. It also has a control word that holds an enable bit, a reload-request bit, a 3-bit power-of-two prescaler and a one-shot selector. When a running counter is at zero on a prescaled tick, the channel raises its expiry flag. In periodic mode it then starts again from the interval. In one-shot mode it halts and drops its own enable.

Software reaches the block through a synchronous 32-bit register port. Requests use valid/ready, with `req_ready` held high at all times, so the block never applies back-pressure. A read returns its data one cycle after it is accepted, with `rsp_valid` high for that one cycle. There is no response ready, so the requester must take the data in that cycle.

A shared enable register and a shared write-1-to-clear status register cover every channel, and each channel drives its own interrupt line. A change of a channel's enable bit reaches the counting logic only after a synchronisation delay. Software that clears the enable must therefore allow the counter to keep moving for two more cycles.

Top module: `dctmr_top`

## Requirements
- R1: After reset every register reads zero, every `irq` bit is low and `rsp_valid` is low.
- R2: A running channel decrements once every 2^p cycles, where p is control bits 6:4. Writing 1 to control bit 1 copies the interval into the counter on the next edge, and the bit then reads back as 0. A channel that is neither running nor reloading holds its count.
- R3: Control bit 0 is the enable. It reaches the counter through a two-stage synchroniser, so the first decrement happens on the third edge after the enable write. After enable is cleared, the counter still moves on the two edges after the write.
- R4: When a tick arrives while the count is zero, the channel sets its status bit. In periodic mode (control bit 7 = 0) it loads the interval and keeps running, so one period is interval+1 ticks.
- R5: In one-shot mode (control bit 7 = 1), expiry leaves the count at zero, clears control bit 0 and stops counting at once.
- R6: Status is at offset 0x04, with bit n for channel n. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a new expiry in the same cycle as a clear wins over the clear.
- R7: `irq[n]` is high exactly while status bit n and bit n of the interrupt-enable register (offset 0x00) are both set.
- R8: Channel n registers sit at these offsets: control at 0x20n+0x10, interval low at 0x20n+0x14, interval high at 0x20n+0x18, count low at 0x20n+0x1C, count high at 0x20n+0x20. Unmapped offsets read zero.
- R9: Only bits 23:0 of the interval-high and count-high words exist. Bits 31:24 read zero.
- R10: Reading count low captures that channel's upper 24 count bits. Count high returns this captured value, not the live counter.
- R11: `req_ready` is always high. Every accepted read gives `rsp_valid` high on the next cycle, and `rsp_valid` is low after any cycle with no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always high; no back-pressure |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq | output | NCH (4) | Per-channel interrupt lines |

## Verification
The hardest behaviour to reach from the ports is the tail of a disable. The counter keeps moving for exactly two edges after the enable is cleared, and this can only be seen by comparing two reads whose spacing in cycles is known. The stimulus reads a running count, writes the disable on the very next cycle, reads again after a fixed idle gap, and expects a drop of four rather than two. A second hard case is the race between a write-1-to-clear of the status and the next periodic expiry. It is reached by starting a short interval at a known edge and placing the clear and the status read on chosen cycles around the second expiry.

// File: rtl/dctmr_pkg.sv
package dctmr_pkg;

  // bit positions of the control word as seen on the bus
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_RLD_BIT  = 1;
  localparam int CTL_PRE_LSB  = 4;
  localparam int CTL_ONE_BIT  = 7;
  localparam int PRE_W        = 3;

  typedef struct packed {
    logic              oneshot;
    logic [PRE_W-1:0]  pres;
    logic              reload;
    logic              en;
  } ctl_t;

  function automatic ctl_t ctl_unpack(input logic [31:0] w);
    ctl_t c;
    c.en      = w[CTL_EN_BIT];
    c.reload  = w[CTL_RLD_BIT];
    c.pres    = w[CTL_PRE_LSB +: PRE_W];
    c.oneshot = w[CTL_ONE_BIT];
    return c;
  endfunction

  function automatic logic [31:0] ctl_pack(input ctl_t c);
    logic [31:0] w;
    w = '0;
    w[CTL_EN_BIT]              = c.en;
    w[CTL_RLD_BIT]             = c.reload;
    w[CTL_PRE_LSB +: PRE_W]    = c.pres;
    w[CTL_ONE_BIT]             = c.oneshot;
    return w;
  endfunction

endpackage

// File: rtl/dctmr_ensync.sv
module dctmr_ensync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic flush_i,
  output logic run_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (flush_i) sr_q <= '0;
    else              sr_q <= (sr_q << 1) | STAGES'(en_i);
  end

  assign run_o = sr_q[STAGES-1];
endmodule

// File: rtl/dctmr_prescale.sv
module dctmr_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pres_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q, mask;

  assign mask   = ~({DIV_W{1'b1}} << pres_i);
  assign tick_o = run_i && (div_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (!run_i) div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/dctmr_channel.sv
module dctmr_channel
  import dctmr_pkg::*;
#(
  parameter int CNT_W       = 56,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ival_lo_we,
  input  logic             ival_hi_we,
  input  logic [31:0]      wdata,
  output ctl_t             ctl_o,
  output logic [CNT_W-1:0] ival_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             expire_o
);
  localparam int HI_W = CNT_W - 32;

  ctl_t             ctl_q;
  logic [CNT_W-1:0] ival_q, cnt_q;
  logic             run, tick, stop_now;

  assign expire_o = tick && (cnt_q == '0);
  assign stop_now = expire_o && ctl_q.oneshot;

  dctmr_ensync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .en_i(ctl_q.en), .flush_i(stop_now), .run_o(run)
  );

  dctmr_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .run_i(run), .pres_i(ctl_q.pres), .tick_o(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_unpack(wdata);
    end else begin
      if (ctl_q.reload) ctl_q.reload <= 1'b0;
      if (stop_now)     ctl_q.en     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= '0;
    end else begin
      if (ival_lo_we) ival_q[31:0]       <= wdata;
      if (ival_hi_we) ival_q[CNT_W-1:32] <= wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (ctl_q.reload)               cnt_q <= ival_q;
    else if (expire_o && !ctl_q.oneshot) cnt_q <= ival_q;
    else if (tick && !expire_o)          cnt_q <= cnt_q - 1'b1;
  end

  assign ctl_o  = ctl_q;
  assign ival_o = ival_q;
  assign cnt_o  = cnt_q;
  assign run_o  = run;
endmodule

// File: rtl/dctmr_top.sv
module dctmr_top
  import dctmr_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CNT_W       = 56,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int HI_W      = CNT_W - 32;
  localparam int STRIDE    = 32;
  localparam int OFF_CTL   = 16;
  localparam int OFF_IVLO  = 20;
  localparam int OFF_IVHI  = 24;
  localparam int OFF_CNLO  = 28;
  localparam int OFF_CNHI  = 32;
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);

  logic wr_go, rd_go;
  logic [NCH-1:0] ie_q, status_q, expire_v, run_v, reload_v;
  ctl_t [NCH-1:0] ctl_a;
  logic [NCH-1:0][CNT_W-1:0] ival_v, cnt_v;
  logic [NCH-1:0][HI_W-1:0]  snap_q;
  logic [31:0] rd_mux;

  assign req_ready = 1'b1;
  assign wr_go = req_valid && req_write;
  assign rd_go = req_valid && !req_write;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(STRIDE * n);
    logic ctl_we, lo_we, hi_we;
    assign ctl_we = wr_go && (req_addr == BASE + ADDR_W'(OFF_CTL));
    assign lo_we  = wr_go && (req_addr == BASE + ADDR_W'(OFF_IVLO));
    assign hi_we  = wr_go && (req_addr == BASE + ADDR_W'(OFF_IVHI));

    dctmr_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) chan_i (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_we), .ival_lo_we(lo_we), .ival_hi_we(hi_we),
      .wdata(req_wdata),
      .ctl_o(ctl_a[n]), .ival_o(ival_v[n]), .cnt_o(cnt_v[n]),
      .run_o(run_v[n]), .expire_o(expire_v[n])
    );

    assign reload_v[n] = ctl_a[n].reload;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) snap_q[n] <= '0;
      else if (rd_go && req_addr == BASE + ADDR_W'(OFF_CNLO))
        snap_q[n] <= cnt_v[n][CNT_W-1:32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= '0;
      status_q <= '0;
    end else begin
      if (wr_go && req_addr == A_IE) ie_q <= req_wdata[NCH-1:0];
      status_q <= (status_q & ~((wr_go && req_addr == A_STAT) ? req_wdata[NCH-1:0] : '0))
                  | expire_v;
    end
  end

  assign irq = status_q & ie_q;

  always_comb begin
    rd_mux = '0;
    if (req_addr == A_IE)   rd_mux = 32'(ie_q);
    if (req_addr == A_STAT) rd_mux = 32'(status_q);
    for (int n = 0; n < NCH; n++) begin
      if (req_addr == ADDR_W'(STRIDE * n + OFF_CTL))  rd_mux = ctl_pack(ctl_a[n]);
      if (req_addr == ADDR_W'(STRIDE * n + OFF_IVLO)) rd_mux = ival_v[n][31:0];
      if (req_addr == ADDR_W'(STRIDE * n + OFF_IVHI)) rd_mux = 32'(ival_v[n][CNT_W-1:32]);
      if (req_addr == ADDR_W'(STRIDE * n + OFF_CNLO)) rd_mux = cnt_v[n][31:0];
      if (req_addr == ADDR_W'(STRIDE * n + OFF_CNHI)) rd_mux = 32'(snap_q[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dctmr_chk.sv
module dctmr_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 56
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic                      rsp_valid,
  input logic [NCH-1:0]            run_v,
  input logic [NCH-1:0]            reload_v,
  input logic [NCH-1:0]            status_q,
  input logic [NCH-1:0][CNT_W-1:0] cnt_v,
  input logic [NCH-1:0][CNT_W-1:0] ival_v
);
  // R11
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R11
  rsp_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  for (genvar g = 0; g < NCH; g++) begin : g_c
    // R2
    reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload_v[g] |=> (cnt_v[g] == $past(ival_v[g])));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_v[g] && !reload_v[g]) |=> $stable(cnt_v[g]));
    // R4
    flag_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[g]) |-> $past(run_v[g]));
  end
endmodule

bind dctmr_top dctmr_chk #(.NCH(NCH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .run_v(run_v), .reload_v(reload_v),
  .status_q(status_q), .cnt_v(cnt_v), .ival_v(ival_v)
);

// File: tb/dctmr_top_tb_top.sv
module dctmr_top_tb_top;
  localparam int NCH = 4;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NCH-1:0] irq;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dctmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic [2:0]  pres;
    logic [55:0] ival;
    logic [15:0] idle;
    logic [55:0] expv;
  } vec_t;

  // expected = ival - floor((idle-2) / 2^pres)
  localparam vec_t VECS [7] = '{
    '{2'd0, 3'd0, 56'd100,                16'd10,  56'd92},
    '{2'd1, 3'd0, 56'h0000_0001_0000_0003, 16'd7,  56'h0000_0000_FFFF_FFFE},
    '{2'd0, 3'd2, 56'd50,                 16'd14,  56'd47},
    '{2'd1, 3'd7, 56'd10,                 16'd300, 56'd8},
    '{2'd0, 3'd3, 56'hAB_CDEF_0123_4567,  16'd2,   56'hAB_CDEF_0123_4567},
    '{2'd3, 3'd1, 56'd1000,               16'd21,  56'd991},
    '{2'd2, 3'd0, 56'hFF_FFFF_FFFF_FFFF,  16'd5,   56'hFF_FFFF_FFFF_FFFC}
  };

  function automatic logic [7:0] a_ctl(int c);  return 8'(32*c + 16); endfunction
  function automatic logic [7:0] a_ivl(int c);  return 8'(32*c + 20); endfunction
  function automatic logic [7:0] a_ivh(int c);  return 8'(32*c + 24); endfunction
  function automatic logic [7:0] a_cnl(int c);  return 8'(32*c + 28); endfunction
  function automatic logic [7:0] a_cnh(int c);  return 8'(32*c + 32); endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT && !done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired got %0d exp <%0d", cyc, LIMIT);
      summary();
    end
  end

  initial begin
    logic [31:0] d, a;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 ready", 64'(req_ready), 64'd1);
    bus_rd(a_ctl(0), d); chk("R1 ctl0", 64'(d), 64'd0);
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
    idle(1); chk("R11 rsp idle", 64'(rsp_valid), 64'd0);
    bus_rd(8'h04, d); chk("R1 status", 64'(d), 64'd0);
    bus_rd(a_cnl(2), d); chk("R1 cnt2", 64'(d), 64'd0);

    // vector walk: R2 R3 R8 R10
    foreach (VECS[i]) begin
      bus_wr(a_ctl(VECS[i].ch), 32'd0);
      idle(3);
      bus_wr(a_ivl(VECS[i].ch), VECS[i].ival[31:0]);
      bus_wr(a_ivh(VECS[i].ch), 32'(VECS[i].ival[55:32]));
      bus_wr(a_ctl(VECS[i].ch), 32'(VECS[i].pres) << 4 | 32'h3);
      idle(int'(VECS[i].idle));
      bus_rd(a_cnl(VECS[i].ch), d);
      chk("R2 R3 count low", 64'(d), 64'(VECS[i].expv[31:0]));
      bus_rd(a_cnh(VECS[i].ch), d);
      chk("R10 count high", 64'(d), 64'(VECS[i].expv[55:32]));
    end
    for (int c = 0; c < NCH; c++) bus_wr(a_ctl(c), 32'd0);
    idle(4);
    bus_wr(8'h04, 32'hF);

    // R9 unimplemented bits, R8 unmapped
    bus_wr(a_ivh(1), 32'hFFFF_FFFF);
    bus_rd(a_ivh(1), d); chk("R9 ival hi", 64'(d), 64'h00FF_FFFF);
    bus_rd(8'h08, d);    chk("R8 unmapped", 64'(d), 64'd0);

    // R4 R6 R7 periodic expiry, status and irq, ch1 interval 4
    bus_wr(a_ivl(1), 32'd4);
    bus_wr(a_ivh(1), 32'd0);
    bus_wr(8'h00, 32'h2);
    bus_wr(a_ctl(1), 32'h3);          // edge W
    idle(6); chk("R4 R7 irq before expiry", 64'(irq), 64'd0);
    idle(1); chk("R4 R7 irq at expiry", 64'(irq), 64'h2);
    bus_rd(a_cnl(1), d); chk("R4 reload on expiry", 64'(d), 64'd4);
    bus_wr(8'h04, 32'h0);
    bus_rd(8'h04, d); chk("R6 write zero keeps", 64'(d), 64'h2);
    bus_wr(8'h04, 32'h2);
    bus_rd(8'h04, d); chk("R6 w1c", 64'(d), 64'h0);
    bus_wr(8'h00, 32'h0);
    idle(1); chk("R7 masked irq", 64'(irq), 64'd0);
    bus_rd(8'h04, d); chk("R4 second expiry", 64'(d), 64'h2);
    bus_wr(a_ctl(1), 32'd0);
    idle(4);
    bus_wr(8'h04, 32'hF);

    // R5 one-shot on ch2, interval 3
    bus_wr(a_ivl(2), 32'd3);
    bus_wr(a_ivh(2), 32'd0);
    bus_wr(a_ctl(2), 32'h83);
    idle(8);
    bus_rd(a_ctl(2), d);  chk("R5 R2 ctl after one-shot", 64'(d), 64'h80);
    bus_rd(a_cnl(2), d);  chk("R5 count zero", 64'(d), 64'd0);
    bus_rd(8'h04, d);     chk("R5 status", 64'(d), 64'h4);
    idle(5);
    bus_rd(a_cnl(2), d);  chk("R5 stays zero", 64'(d), 64'd0);

    // R10 snapshot on ch0, interval 0x1_00000001
    bus_wr(a_ivl(0), 32'd1);
    bus_wr(a_ivh(0), 32'd1);
    bus_wr(a_ctl(0), 32'h3);
    idle(3);
    bus_rd(a_cnl(0), d);  chk("R10 low at boundary", 64'(d), 64'd0);
    idle(3);
    bus_rd(a_cnh(0), d);  chk("R10 held high", 64'(d), 64'd1);
    bus_rd(a_cnl(0), d);
    bus_rd(a_cnh(0), d);  chk("R10 new high", 64'(d), 64'd0);
    bus_wr(a_ctl(0), 32'd0);

    // R3 delayed disable on ch3, interval 1000
    bus_wr(a_ivl(3), 32'd1000);
    bus_wr(a_ivh(3), 32'd0);
    bus_wr(a_ctl(3), 32'h3);
    idle(5);
    bus_rd(a_cnl(3), a);  chk("R3 start delay", 64'(a), 64'd997);
    bus_wr(a_ctl(3), 32'd0);
    idle(5);
    bus_rd(a_cnl(3), d);  chk("R3 counts after disable", 64'(d), 64'(a - 32'd4));
    idle(3);
    bus_rd(a_cnl(3), d);  chk("R3 stopped", 64'(d), 64'(a - 32'd4));

    done = 1;
    summary();
  end
endmodule